// File: doc/BRIEF.md
# Stack Access Classifier

This block labels each load or store as a stack access or not. It works alongside the address generation stage. It never waits for the computed effective address. Instead, it takes the raw address components and compares the high-order bits of each one with the high-order bits of the current stack pointer. These components are the base register, the index register and the sign-extended displacement. The access is tagged as stack when any component that is present falls in the same aligned region as the stack pointer. Because no comparison sits behind the address adder, the classification adds no delay to the path that starts the memory access.

The result is registered, so the flag comes out one cycle after the request, together with its own valid bit. This lines it up with a registered address-generation result. The flag is only a hint. Downstream logic may use it to steer accesses, but it must stay correct whatever value the flag takes. Accesses issued in system mode are always tagged non-stack. The region size is set by a parameter: 23 ignored low bits (an 8 MB region) by default, and 13 bits for an 8 KB region.

Top module: `stack_hint_unit`

## Requirements
- R1: For a valid non-system request, stack_o is 1 if and only if at least one present component equals sp_i in every bit from bit REGION_BITS up to bit ADDR_W-1.
- R2: With the default REGION_BITS of 23, bits 22 down to 0 of every component and of sp_i have no effect on the result. A difference in bit 23 alone makes a component mismatch.
- R3: A request with sys_mode_i high always produces stack_o equal to 0, even when a component matches.
- R4: When index_en_i is 0, the index component cannot produce a match, whatever value index_i holds.
- R5: A displacement equal to zero is treated as absent and cannot produce a match, even when the stack pointer lies in region zero.
- R6: When base_en_i is 0, the base component cannot produce a match.
- R7: valid_o is 1 in exactly the cycle after a cycle with valid_i high. The flag stack_o is 0 whenever valid_o is 0.
- R8: Inputs presented while valid_i is low produce no result: valid_o and stack_o both stay 0 in the next cycle.
- R9: If the stack pointer moves but stays within one aligned region, repeating the same request gives the same classification.
- R10: After reset is asserted, valid_o and stack_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A request is present this cycle |
| base_i | input | ADDR_W | Base register value |
| base_en_i | input | 1 | The access uses a base register |
| index_i | input | ADDR_W | Index register value |
| index_en_i | input | 1 | The access uses an index register |
| disp_i | input | ADDR_W | Sign-extended displacement |
| sp_i | input | ADDR_W | Current stack pointer |
| sys_mode_i | input | 1 | The request is issued in system mode |
| valid_o | output | 1 | The registered classification is valid |
| stack_o | output | 1 | Registered stack hint |

## Verification
The directed scenarios drive a match through each component on its own: base, index and an absolute displacement. This shows that the OR covers every path and that no path is left out. A mismatch that lies only in bit 23, next to a match that differs in every bit below bit 23, locates the region boundary exactly. Matching components are then paired with a cleared enable, a zero displacement next to a region-zero stack pointer, or system mode, to show that each mask overrides a hit. Repeating one request while the stack pointer moves inside its region, and then across the region boundary, tests the consistency of the result. Strobe-less cycles test that no result is produced without a request.

// File: rtl/stack_hint_pkg.sv
package stack_hint_pkg;
  localparam int unsigned NUM_COMP = 3;
  typedef enum logic [1:0] {
    COMP_BASE  = 2'd0,
    COMP_INDEX = 2'd1,
    COMP_DISP  = 2'd2
  } comp_e;
endpackage

// File: rtl/shc_region_match.sv
module shc_region_match #(
  parameter int unsigned ADDR_W      = 64,
  parameter int unsigned REGION_BITS = 23
) (
  input  logic [ADDR_W-1:0] comp_i,
  input  logic [ADDR_W-1:0] sp_i,
  output logic              match_o
);
  localparam int unsigned HI_W = ADDR_W - REGION_BITS;

  logic [HI_W-1:0] comp_hi, sp_hi;
  assign comp_hi = comp_i[ADDR_W-1:REGION_BITS];
  assign sp_hi   = sp_i[ADDR_W-1:REGION_BITS];
  assign match_o = (comp_hi == sp_hi);

  initial begin
    AST_REGION_PARAM: assert (REGION_BITS > 0 && REGION_BITS < ADDR_W); // R2
  end
endmodule

// File: rtl/shc_vote.sv
module shc_vote #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] match_i,
  input  logic [N-1:0] present_i,
  input  logic         sys_mode_i,
  output logic         hit_o
);
  assign hit_o = ~sys_mode_i & (|(match_i & present_i));

  always_comb begin
    AST_VOTE_SYS: assert (!(sys_mode_i && hit_o)); // R3
    AST_VOTE_ABSENT: assert (!(hit_o && ((match_i & present_i) == '0))); // R1
  end
endmodule

// File: rtl/stack_hint_unit.sv
module stack_hint_unit
  import stack_hint_pkg::*;
#(
  parameter int unsigned ADDR_W      = 64,
  parameter int unsigned REGION_BITS = 23
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              base_en_i,
  input  logic [ADDR_W-1:0] index_i,
  input  logic              index_en_i,
  input  logic [ADDR_W-1:0] disp_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic              sys_mode_i,
  output logic              valid_o,
  output logic              stack_o
);
  logic [NUM_COMP-1:0][ADDR_W-1:0] comp;
  logic [NUM_COMP-1:0]             present;
  logic [NUM_COMP-1:0]             match;
  logic                            hit;

  assign comp[COMP_BASE]     = base_i;
  assign comp[COMP_INDEX]    = index_i;
  assign comp[COMP_DISP]     = disp_i;
  assign present[COMP_BASE]  = base_en_i;
  assign present[COMP_INDEX] = index_en_i;
  assign present[COMP_DISP]  = |disp_i; // zero displacement = absent

  for (genvar g = 0; g < NUM_COMP; g++) begin : g_cmp
    shc_region_match #(
      .ADDR_W(ADDR_W),
      .REGION_BITS(REGION_BITS)
    ) u_match (
      .comp_i (comp[g]),
      .sp_i   (sp_i),
      .match_o(match[g])
    );
  end

  shc_vote #(.N(NUM_COMP)) u_vote (
    .match_i   (match),
    .present_i (present),
    .sys_mode_i(sys_mode_i),
    .hit_o     (hit)
  );

  logic valid_q, stack_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      stack_q <= 1'b0;
    end else begin
      valid_q <= valid_i;
      stack_q <= valid_i & hit;
    end
  end

  assign valid_o = valid_q;
  assign stack_o = stack_q;

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R7
  AST_NO_REQ_NO_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !stack_o)); // R8
  AST_SYS_FORCES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sys_mode_i) |=> !stack_o); // R3
  AST_BASE_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sys_mode_i && base_en_i &&
     base_i[ADDR_W-1:REGION_BITS] == sp_i[ADDR_W-1:REGION_BITS]) |=> stack_o); // R1
  AST_IDLE_FLAG_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !stack_o); // R7
endmodule

// File: tb/stack_hint_unit_test.sv
module stack_hint_unit_test;
  localparam int AW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid = 1'b0;
  logic [AW-1:0] base = '0, index = '0, disp = '0, sp = '0;
  logic          base_en = 1'b0, index_en = 1'b0, sys = 1'b0;
  logic          valid_o, stack_o;
  int            n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  stack_hint_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid),
    .base_i(base), .base_en_i(base_en),
    .index_i(index), .index_en_i(index_en),
    .disp_i(disp), .sp_i(sp), .sys_mode_i(sys),
    .valid_o(valid_o), .stack_o(stack_o)
  );

  localparam logic [AW-1:0] SP0 = 64'h0000_7ffc_1234_5678;
  localparam logic [AW-1:0] B23 = 64'h0000_0000_0080_0000;

  task automatic check(input string req, input logic got, input logic exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0b exp=%0b", req, got, exp);
    end
  endtask

  // issue one request at negedge, sample after the next posedge
  task automatic req(input logic [AW-1:0] b, input logic be,
                     input logic [AW-1:0] x, input logic xe,
                     input logic [AW-1:0] d, input logic [AW-1:0] s,
                     input logic sm, input logic exp, input string tag);
    @(negedge clk);
    valid = 1'b1; base = b; base_en = be; index = x; index_en = xe;
    disp = d; sp = s; sys = sm;
    @(posedge clk); #1;
    valid = 1'b0;
    check(tag, valid_o, 1'b1);
    check(tag, stack_o, exp);
  endtask

  task automatic t_reset();
    #1;
    check("R10 valid", valid_o, 1'b0);
    check("R10 stack", stack_o, 1'b0);
  endtask

  task automatic t_components();
    req(SP0 + 64'h40, 1, '0, 0, 64'h10, SP0, 0, 1, "R1 base hit");
    req(64'h1000, 1, SP0 - 64'h80, 1, 64'h10, SP0, 0, 1, "R1 index hit");
    req(64'h1000, 1, '0, 0, SP0 + 64'h8, SP0, 0, 1, "R1 disp hit");
    req(64'h1000, 1, 64'h2000, 1, 64'h10, SP0, 0, 0, "R1 all miss");
  endtask

  task automatic t_boundary();
    req({SP0[AW-1:23], 23'h7fffff}, 1, '0, 0, '0, {SP0[AW-1:23], 23'h0}, 0, 1, "R2 low bits ignored");
    req(SP0 ^ B23, 1, '0, 0, '0, SP0, 0, 0, "R2 bit23 differs");
  endtask

  task automatic t_masks();
    req(SP0, 1, SP0, 1, SP0, SP0, 1, 0, "R3 sys mode");
    req(64'h1000, 1, SP0, 0, 64'h10, SP0, 0, 0, "R4 index disabled");
    req(64'h0100_0000, 1, '0, 0, '0, 64'h1000, 0, 0, "R5 zero disp masked");
    req(SP0, 0, '0, 0, '0, SP0, 0, 0, "R6 base disabled");
  endtask

  task automatic t_strobe();
    @(negedge clk);
    valid = 1'b0; base = SP0; base_en = 1'b1; sp = SP0; sys = 1'b0;
    @(posedge clk); #1;
    check("R8 valid", valid_o, 1'b0);
    check("R8 stack", stack_o, 1'b0);
    req(SP0, 1, '0, 0, '0, SP0, 0, 1, "R7 one-cycle");
    @(posedge clk); #1;
    check("R7 valid drop", valid_o, 1'b0);
    check("R7 stack drop", stack_o, 1'b0);
  endtask

  task automatic t_consistency();
    logic [AW-1:0] a = {SP0[AW-1:23], 23'h100};
    req(a, 1, '0, 0, '0, {SP0[AW-1:23], 23'h7ff000}, 0, 1, "R9 sp high in region");
    req(a, 1, '0, 0, '0, {SP0[AW-1:23], 23'h000010}, 0, 1, "R9 sp low in region");
    req(a, 1, '0, 0, '0, {SP0[AW-1:23], 23'h0} - 64'h10, 0, 0, "R9 sp left region");
  endtask

  initial begin
    t_reset();
    #22 rst_n = 1'b1;
    t_components();
    t_boundary();
    t_masks();
    t_strobe();
    t_consistency();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule